// File: doc/BRIEF.md
# Four-Byte Packing Data Buffer

This block is a four-byte shift buffer that sits between a 16-bit host data port and a byte-wide serial engine. All traffic shares one 32-bit store. The host loads transmit data two bytes at a time, or one byte for a final odd-length write. The engine drains those bytes one at a time, oldest first. In the other direction the engine deposits received bytes one at a time, and the host collects them two at a time. A `big_endian` input decides how a 16-bit host word maps onto the byte order on the serial side.

The buffer keeps separate transmit and receive fill levels. It maintains five status flags: transmit ready, transmit underflow, receive ready, receive overrun and single-byte read. A controller around it reads these flags to decide when to feed or drain the buffer. Transfer sequencing and interrupt generation belong to that controller.

Only one operation is serviced per clock, because every operation moves the same store. A host write wins over a host read, which wins over an engine pop, which wins over an engine push. A lower-priority strobe raised in the same cycle is not serviced.

Top module: `byte_pack_buffer`

## Requirements
- R1: After reset both levels are 0, all five flags are 0, and `host_rd_data`, `eng_tx_byte` and `eng_tx_avail` are 0.
- R2: An accepted 16-bit write shifts the store up by two byte lanes, loads the word into lanes 1 and 0, and adds 2 to the transmit level. With `big_endian`=1, `host_wr_data[15:8]` is sent first; with `big_endian`=0, `host_wr_data[7:0]` is sent first.
- R3: An accepted 8-bit write (`host_wr_byte`=1) shifts the store up by one lane, loads `host_wr_data[7:0]` into lane 0, and adds 1 to the transmit level.
- R4: A host write of either size, made while the transmit level is above 2, is refused. The store and the transmit level are left unchanged.
- R5: A pop presents the byte in lane (transmit level − 1) on `eng_tx_byte` and lowers the level by 1. A pop at level 0 changes nothing except setting `tx_underflow`.
- R6: A push writes `eng_rx_byte` into lane (receive level), raises the level by 1, sets `rx_ready` and clears `rx_single`. A push at level 4 is dropped and sets `rx_overrun`.
- R7: `host_rd_data` carries lanes 0 and 1. It is {lane0, lane1} when `big_endian`=1 and {lane1, lane0} when `big_endian`=0.
- R8: A read at receive level 1 sets `rx_single` and empties the buffer. At level 2 it empties the buffer without a shift. Above level 2 it shifts the store down by two lanes and lowers the level by 2. At level 0 it leaves the level and the store unchanged.
- R9: An accepted write clears `tx_underflow`, and clears `tx_ready` if the new transmit level is above 2. A pop that leaves the transmit level at 2 or below sets `tx_ready`.
- R10: Every read clears `rx_overrun`. A read that leaves the receive level at 0 clears `rx_ready`.
- R11: Only one operation is serviced per cycle, with priority write > read > pop > push. Lower strobes raised in the same cycle have no effect.
- R12: Neither level ever exceeds 4 or wraps below 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| big_endian | input | 1 | Byte order select for host accesses |
| host_wr_en | input | 1 | Host write strobe |
| host_wr_byte | input | 1 | 1: the write carries only `host_wr_data[7:0]` |
| host_wr_data | input | 16 | Host write data |
| host_rd_en | input | 1 | Host read strobe (consumes bytes) |
| host_rd_data | output | 16 | Lanes 0 and 1 in host order |
| eng_tx_pop | input | 1 | Engine takes one transmit byte |
| eng_tx_byte | output | 8 | Next transmit byte (0 when empty) |
| eng_tx_avail | output | 1 | Transmit level is nonzero |
| eng_rx_push | input | 1 | Engine delivers one received byte |
| eng_rx_byte | input | 8 | Received byte |
| tx_level | output | 3 | Transmit bytes held |
| rx_level | output | 3 | Receive bytes held |
| tx_ready | output | 1 | Room for another host word |
| tx_underflow | output | 1 | Pop made with nothing held |
| rx_ready | output | 1 | Received data waiting |
| rx_overrun | output | 1 | Received byte dropped while full |
| rx_single | output | 1 | Last read returned only one valid byte |

## Verification
The hardest state to reach is a store whose lanes hold a mix of old transmit data and newly pushed receive bytes, followed by a down-shifting read. Only then does the second half of a read show whether lane contents moved correctly. The stimulus reaches it by running transmit traffic first, then pushing three bytes and reading twice, so the final read exposes a lane that came from the shift. Priority is exercised by raising two strobes in the same cycle and checking the levels that result.

// File: rtl/bpb_pkg.sv
`timescale 1ns/1ps
package bpb_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned HALF_W = 2 * BYTE_W;

  typedef enum logic [2:0] {
    OP_IDLE  = 3'd0,
    OP_WRITE = 3'd1,
    OP_READ  = 3'd2,
    OP_POP   = 3'd3,
    OP_PUSH  = 3'd4
  } op_e;

  // Arrange a host word as {first_sent, second_sent}.
  function automatic logic [HALF_W-1:0] order_write(input logic [HALF_W-1:0] d,
                                                    input logic be);
    if (be) return d;
    return {d[BYTE_W-1:0], d[HALF_W-1:BYTE_W]};
  endfunction

  // Present lanes 0 and 1 to the host.
  function automatic logic [HALF_W-1:0] order_read(input logic [BYTE_W-1:0] b0,
                                                   input logic [BYTE_W-1:0] b1,
                                                   input logic be);
    if (be) return {b0, b1};
    return {b1, b0};
  endfunction
endpackage

// File: rtl/bpb_arbiter.sv
`timescale 1ns/1ps
module bpb_arbiter
  import bpb_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic wr_req,
  input  logic rd_req,
  input  logic pop_req,
  input  logic push_req,
  output op_e  op
);
  always_comb begin
    if (wr_req)        op = OP_WRITE;
    else if (rd_req)   op = OP_READ;
    else if (pop_req)  op = OP_POP;
    else if (push_req) op = OP_PUSH;
    else               op = OP_IDLE;
  end

  AST_WRITE_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req |-> op == OP_WRITE); // R11
  AST_PUSH_YIELDS: assert property (@(posedge clk) disable iff (!rst_n)
    (push_req && (wr_req || rd_req || pop_req)) |-> op != OP_PUSH); // R11
endmodule

// File: rtl/bpb_store.sv
`timescale 1ns/1ps
module bpb_store
  import bpb_pkg::*;
#(
  parameter int unsigned DEPTH = 4,
  localparam int unsigned CW = $clog2(DEPTH + 1),
  localparam int unsigned DW = DEPTH * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  op_e               op,
  input  logic              be,
  input  logic              wr_byte,
  input  logic [HALF_W-1:0] wr_data,
  input  logic [BYTE_W-1:0] push_byte,
  output logic [HALF_W-1:0] rd_data,
  output logic [BYTE_W-1:0] tx_byte,
  output logic              tx_avail,
  output logic [CW-1:0]     tx_lvl,
  output logic [CW-1:0]     rx_lvl,
  output logic              wr_accept,
  output logic              tx_roomy,
  output logic              pop_ok,
  output logic              pop_empty,
  output logic              push_ok,
  output logic              push_full,
  output logic              rd_event,
  output logic              rd_single,
  output logic              rd_drain
);
  localparam logic [CW-1:0] LIM  = CW'(DEPTH - 2);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  logic [DW-1:0] store_q, store_d;
  logic [CW-1:0] tx_q, tx_d, rx_q, rx_d;
  logic          wr_refuse;

  // Named events shared with the flag unit and the assertions.
  assign wr_accept = (op == OP_WRITE) && (tx_q <= LIM);
  assign wr_refuse = (op == OP_WRITE) && (tx_q > LIM);
  assign pop_ok    = (op == OP_POP) && (tx_q != '0);
  assign pop_empty = (op == OP_POP) && (tx_q == '0);
  assign push_ok   = (op == OP_PUSH) && (rx_q < FULL);
  assign push_full = (op == OP_PUSH) && (rx_q >= FULL);
  assign rd_event  = (op == OP_READ);
  assign rd_single = rd_event && (rx_q == CW'(1));
  assign rd_drain  = rd_event && (rx_d == '0);
  assign tx_roomy  = (tx_d <= LIM);

  always_comb begin
    store_d = store_q;
    tx_d    = tx_q;
    rx_d    = rx_q;
    unique case (op)
      OP_WRITE: begin
        if (wr_accept) begin
          if (wr_byte) begin
            store_d = (store_q << BYTE_W) | DW'(wr_data[BYTE_W-1:0]);
            tx_d    = tx_q + CW'(1);
          end else begin
            store_d = (store_q << HALF_W) | DW'(order_write(wr_data, be));
            tx_d    = tx_q + CW'(2);
          end
        end
      end
      OP_READ: begin
        if (rx_q > CW'(2)) begin
          store_d = store_q >> HALF_W;
          rx_d    = rx_q - CW'(2);
        end else begin
          rx_d = '0;
        end
      end
      OP_POP: begin
        if (pop_ok) tx_d = tx_q - CW'(1);
      end
      OP_PUSH: begin
        if (push_ok) begin
          for (int i = 0; i < int'(DEPTH); i++) begin
            if (rx_q == CW'(i)) store_d[i*BYTE_W +: BYTE_W] = push_byte;
          end
          rx_d = rx_q + CW'(1);
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      store_q <= '0;
      tx_q    <= '0;
      rx_q    <= '0;
    end else begin
      store_q <= store_d;
      tx_q    <= tx_d;
      rx_q    <= rx_d;
    end
  end

  // Oldest transmit byte sits at lane (tx_q - 1).
  always_comb begin
    tx_byte = '0;
    for (int i = 0; i < int'(DEPTH); i++) begin
      if (tx_q == CW'(i + 1)) tx_byte = store_q[i*BYTE_W +: BYTE_W];
    end
  end

  assign rd_data  = order_read(store_q[0 +: BYTE_W], store_q[BYTE_W +: BYTE_W], be);
  assign tx_avail = (tx_q != '0);
  assign tx_lvl   = tx_q;
  assign rx_lvl   = rx_q;

  AST_LEVELS_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_q <= FULL) && (rx_q <= FULL)); // R12
  AST_REFUSED_WRITE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_refuse |=> $stable(store_q) && $stable(tx_q)); // R4
  AST_POP_STEPS_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    pop_ok |=> tx_q == $past(tx_q) - CW'(1)); // R5
  AST_FULL_PUSH_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    push_full |=> $stable(store_q) && (rx_q == FULL)); // R6
  AST_READ_SHIFTS_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_event && rx_q > CW'(2)) |=>
      store_q[0 +: BYTE_W] == $past(store_q[2*BYTE_W +: BYTE_W])); // R8
endmodule

// File: rtl/bpb_flags.sv
`timescale 1ns/1ps
module bpb_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_accept,
  input  logic tx_roomy,
  input  logic pop_ok,
  input  logic pop_empty,
  input  logic push_ok,
  input  logic push_full,
  input  logic rd_event,
  input  logic rd_single,
  input  logic rd_drain,
  output logic tx_ready,
  output logic tx_underflow,
  output logic rx_ready,
  output logic rx_overrun,
  output logic rx_single
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_ready     <= 1'b0;
      tx_underflow <= 1'b0;
      rx_ready     <= 1'b0;
      rx_overrun   <= 1'b0;
      rx_single    <= 1'b0;
    end else begin
      if (pop_empty)                   tx_underflow <= 1'b1;
      else if (wr_accept)              tx_underflow <= 1'b0;
      if (wr_accept && !tx_roomy)      tx_ready     <= 1'b0;
      else if (pop_ok && tx_roomy)     tx_ready     <= 1'b1;
      if (push_ok)                     rx_ready     <= 1'b1;
      else if (rd_drain)               rx_ready     <= 1'b0;
      if (push_full)                   rx_overrun   <= 1'b1;
      else if (rd_event)               rx_overrun   <= 1'b0;
      if (rd_single)                   rx_single    <= 1'b1;
      else if (push_ok)                rx_single    <= 1'b0;
    end
  end

  AST_UNDERFLOW_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    pop_empty |=> tx_underflow); // R5
  AST_WRITE_CLEARS_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    wr_accept |=> !tx_underflow); // R9
  AST_READ_CLEARS_OVERRUN: assert property (@(posedge clk) disable iff (!rst_n)
    rd_event |=> !rx_overrun); // R10
  AST_SINGLE_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    rd_single |=> rx_single); // R8
  AST_PUSH_READY: assert property (@(posedge clk) disable iff (!rst_n)
    push_ok |=> rx_ready && !rx_single); // R6
endmodule

// File: rtl/byte_pack_buffer.sv
`timescale 1ns/1ps
module byte_pack_buffer
  import bpb_pkg::*;
#(
  parameter int unsigned DEPTH = 4,
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              big_endian,
  input  logic              host_wr_en,
  input  logic              host_wr_byte,
  input  logic [HALF_W-1:0] host_wr_data,
  input  logic              host_rd_en,
  output logic [HALF_W-1:0] host_rd_data,
  input  logic              eng_tx_pop,
  output logic [BYTE_W-1:0] eng_tx_byte,
  output logic              eng_tx_avail,
  input  logic              eng_rx_push,
  input  logic [BYTE_W-1:0] eng_rx_byte,
  output logic [CW-1:0]     tx_level,
  output logic [CW-1:0]     rx_level,
  output logic              tx_ready,
  output logic              tx_underflow,
  output logic              rx_ready,
  output logic              rx_overrun,
  output logic              rx_single
);
  op_e  op;
  logic wr_accept, tx_roomy, pop_ok, pop_empty;
  logic push_ok, push_full, rd_event, rd_single, rd_drain;

  bpb_arbiter u_arb (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_req   (host_wr_en),
    .rd_req   (host_rd_en),
    .pop_req  (eng_tx_pop),
    .push_req (eng_rx_push),
    .op       (op)
  );

  bpb_store #(.DEPTH(DEPTH)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .op        (op),
    .be        (big_endian),
    .wr_byte   (host_wr_byte),
    .wr_data   (host_wr_data),
    .push_byte (eng_rx_byte),
    .rd_data   (host_rd_data),
    .tx_byte   (eng_tx_byte),
    .tx_avail  (eng_tx_avail),
    .tx_lvl    (tx_level),
    .rx_lvl    (rx_level),
    .wr_accept (wr_accept),
    .tx_roomy  (tx_roomy),
    .pop_ok    (pop_ok),
    .pop_empty (pop_empty),
    .push_ok   (push_ok),
    .push_full (push_full),
    .rd_event  (rd_event),
    .rd_single (rd_single),
    .rd_drain  (rd_drain)
  );

  bpb_flags u_flags (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_accept    (wr_accept),
    .tx_roomy     (tx_roomy),
    .pop_ok       (pop_ok),
    .pop_empty    (pop_empty),
    .push_ok      (push_ok),
    .push_full    (push_full),
    .rd_event     (rd_event),
    .rd_single    (rd_single),
    .rd_drain     (rd_drain),
    .tx_ready     (tx_ready),
    .tx_underflow (tx_underflow),
    .rx_ready     (rx_ready),
    .rx_overrun   (rx_overrun),
    .rx_single    (rx_single)
  );
endmodule

// File: tb/tb_byte_pack_buffer.sv
`timescale 1ns/1ps
module tb_byte_pack_buffer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        big_endian = 1'b0;
  logic        host_wr_en = 1'b0, host_wr_byte = 1'b0, host_rd_en = 1'b0;
  logic [15:0] host_wr_data = '0;
  logic [15:0] host_rd_data;
  logic        eng_tx_pop = 1'b0, eng_rx_push = 1'b0;
  logic [7:0]  eng_rx_byte = '0;
  logic [7:0]  eng_tx_byte;
  logic        eng_tx_avail;
  logic [2:0]  tx_level, rx_level;
  logic        tx_ready, tx_underflow, rx_ready, rx_overrun, rx_single;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // Reference model, built from the requirements.
  logic [31:0] m_st = '0;
  int m_tx = 0, m_rx = 0;
  bit m_txr = 0, m_und = 0, m_rxr = 0, m_ovr = 0, m_sgl = 0;

  logic [7:0]  exp_tx_q[$];
  string       exp_tx_tag[$];
  logic [15:0] exp_rd_q[$];

  always #10 clk = ~clk;  // 50 MHz

  byte_pack_buffer dut (
    .clk(clk), .rst_n(rst_n), .big_endian(big_endian),
    .host_wr_en(host_wr_en), .host_wr_byte(host_wr_byte), .host_wr_data(host_wr_data),
    .host_rd_en(host_rd_en), .host_rd_data(host_rd_data),
    .eng_tx_pop(eng_tx_pop), .eng_tx_byte(eng_tx_byte), .eng_tx_avail(eng_tx_avail),
    .eng_rx_push(eng_rx_push), .eng_rx_byte(eng_rx_byte),
    .tx_level(tx_level), .rx_level(rx_level),
    .tx_ready(tx_ready), .tx_underflow(tx_underflow),
    .rx_ready(rx_ready), .rx_overrun(rx_overrun), .rx_single(rx_single)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic check_state(input string req);
    chk(req, "tx_level", 32'(tx_level), 32'(m_tx));
    chk(req, "rx_level", 32'(rx_level), 32'(m_rx));
    chk(req, "eng_tx_avail", 32'(eng_tx_avail), 32'(m_tx != 0));
    chk(req, "flags {txr,und,rxr,ovr,sgl}",
        32'({tx_ready, tx_underflow, rx_ready, rx_overrun, rx_single}),
        32'({m_txr, m_und, m_rxr, m_ovr, m_sgl}));
  endtask

  // Model operations
  task automatic m_write(input bit b8, input logic [15:0] d, input bit be);
    if (m_tx > 2) return;  // refused
    if (b8) begin
      m_st = {m_st[23:0], d[7:0]};
      m_tx += 1;
    end else begin
      m_st = be ? {m_st[15:0], d[15:8], d[7:0]} : {m_st[15:0], d[7:0], d[15:8]};
      m_tx += 2;
    end
    m_und = 0;
    if (m_tx > 2) m_txr = 0;
  endtask

  task automatic m_read(input bit be);
    exp_rd_q.push_back(be ? {m_st[7:0], m_st[15:8]} : {m_st[15:8], m_st[7:0]});
    m_ovr = 0;
    if (m_rx == 1) begin m_sgl = 1; m_rx = 0; end
    else if (m_rx == 2) m_rx = 0;
    else if (m_rx > 2) begin m_st = m_st >> 16; m_rx -= 2; end
    if (m_rx == 0) m_rxr = 0;
  endtask

  task automatic m_pop(input string tag);
    if (m_tx == 0) begin m_und = 1; return; end
    exp_tx_q.push_back(m_st[8*(m_tx-1) +: 8]);
    exp_tx_tag.push_back(tag);
    m_tx -= 1;
    if (m_tx <= 2) m_txr = 1;
  endtask

  task automatic m_push(input logic [7:0] b);
    if (m_rx == 4) begin m_ovr = 1; return; end
    m_st[8*m_rx +: 8] = b;
    m_rx += 1;
    m_rxr = 1;
    m_sgl = 0;
  endtask

  // Driver: raise strobes for one cycle, model the winning operation.
  task automatic step(input bit wr, input bit b8, input logic [15:0] wd, input bit rd,
                      input bit pp, input bit ps, input logic [7:0] rb, input bit be,
                      input string tag);
    @(negedge clk);
    big_endian = be; host_wr_en = wr; host_wr_byte = b8; host_wr_data = wd;
    host_rd_en = rd; eng_tx_pop = pp; eng_rx_push = ps; eng_rx_byte = rb;
    if (wr) m_write(b8, wd, be);
    else if (rd) m_read(be);
    else if (pp) m_pop(tag);
    else if (ps) m_push(rb);
    @(negedge clk);
    host_wr_en = 0; host_wr_byte = 0; host_rd_en = 0; eng_tx_pop = 0; eng_rx_push = 0;
  endtask

  task automatic wr16(input logic [15:0] d, input bit be, input string tag);
    step(1, 0, d, 0, 0, 0, 8'h0, be, tag);
  endtask
  task automatic wr8(input logic [7:0] d, input string tag);
    step(1, 1, {8'h0, d}, 0, 0, 0, 8'h0, big_endian, tag);
  endtask
  task automatic pop1(input string tag);
    step(0, 0, 16'h0, 0, 1, 0, 8'h0, big_endian, tag);
  endtask
  task automatic push1(input logic [7:0] b, input string tag);
    step(0, 0, 16'h0, 0, 0, 1, b, big_endian, tag);
  endtask
  task automatic rd1(input bit be, input string tag);
    step(0, 0, 16'h0, 1, 0, 0, 8'h0, be, tag);
  endtask

  // Monitor: compare produced data against the expectation queues.
  always @(posedge clk) begin
    if (rst_n && eng_tx_pop && exp_tx_q.size() > 0) begin
      logic [7:0] e;
      string t;
      e = exp_tx_q.pop_front();
      t = exp_tx_tag.pop_front();
      chk(t, "eng_tx_byte", 32'(eng_tx_byte), 32'(e));
    end
    if (rst_n && host_rd_en && exp_rd_q.size() > 0) begin
      logic [15:0] e;
      e = exp_rd_q.pop_front();
      chk("R7", "host_rd_data", 32'(host_rd_data), 32'(e));
    end
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check_state("R1");
    chk("R1", "host_rd_data", 32'(host_rd_data), 32'h0);
    chk("R1", "eng_tx_byte", 32'(eng_tx_byte), 32'h0);

    // R2 little order, two words, drain oldest first
    wr16(16'h1234, 0, "R2"); check_state("R2");
    wr16(16'hABCD, 0, "R2"); check_state("R2");
    pop1("R2"); check_state("R9");
    pop1("R2"); check_state("R9");   // level 2 -> tx_ready set
    pop1("R2"); pop1("R2"); check_state("R5");

    // R5 pop when empty, then R9 write clears underflow, R3 byte write
    pop1("R5"); check_state("R5");
    chk("R5", "eng_tx_byte empty", 32'(eng_tx_byte), 32'h0);
    wr8(8'h5A, "R3"); check_state("R9");
    pop1("R3"); check_state("R3");

    // R2 big order, R3 odd tail, R4 refusals
    wr16(16'h1234, 1, "R2");
    wr8(8'h77, "R3"); check_state("R9");
    wr16(16'hEEFF, 1, "R4"); check_state("R4");
    wr8(8'h99, "R4"); check_state("R4");
    pop1("R4"); pop1("R4"); pop1("R4"); check_state("R4");

    // R6 pushes, R8 shifting read, R7 both orders, single-byte read
    push1(8'h11, "R6"); check_state("R6");
    push1(8'h22, "R6"); push1(8'h33, "R6"); check_state("R6");
    rd1(0, "R8"); check_state("R8");
    rd1(0, "R8"); check_state("R8");
    rd1(1, "R8"); check_state("R8");  // empty read

    // R6 overrun, R12 bound, single cleared by push, R10 clears
    push1(8'hA1, "R6"); check_state("R6");
    push1(8'hA2, "R6"); push1(8'hA3, "R6"); push1(8'hA4, "R6");
    push1(8'hA5, "R12"); check_state("R12");
    rd1(1, "R10"); check_state("R10");
    rd1(1, "R10"); check_state("R10");

    // R11 priority: write beats pop, read beats push, pop beats push
    wr16(16'h4321, 0, "R11");
    step(1, 0, 16'h8765, 0, 1, 0, 8'h0, 0, "R11"); check_state("R11");
    push1(8'h5C, "R11");
    step(0, 0, 16'h0, 1, 0, 1, 8'hC5, 1, "R11"); check_state("R11");
    step(0, 0, 16'h0, 0, 1, 1, 8'hD6, 0, "R11"); check_state("R11");
    pop1("R11"); pop1("R11"); pop1("R11"); check_state("R11");
    pop1("R12"); check_state("R12");

    chk("R7", "read queue drained", 32'(exp_rd_q.size()), 32'h0);
    chk("R5", "tx queue drained", 32'(exp_tx_q.size()), 32'h0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule